// File: doc/BRIEF.md
# Byte-Loaded Countdown Timer with Snapshot

This block is a down-counter loaded and observed through byte-wide write strobes. The host builds a reload value one byte lane at a time. Those writes go only into a holding register, so the live count is not disturbed. A separate start strobe copies the held value into the counter and sets it running. The counter then decrements once per tick enable; in the intended use the tick enable pulses at 2 MHz, so a reload of 64000 spans 32 ms.

Because the counter is wider than the host's data path, the live count is never read directly. A snapshot strobe copies the whole count into a snapshot register in a single cycle. The host can then read both bytes of the snapshot without tearing. Elapsed time in microseconds is (reload − snapshot) / 2.

When a tick arrives with the count at zero, the counter reloads from the holding register and keeps counting. This underflow sets a sticky status bit. A second sticky status bit records an external event input, such as a frame flyback pulse. The host clears either bit by writing a 1 to that bit position of the clear register.

Top module: `byte_cdown_timer`

## Requirements
- R1: After reset the snapshot and status outputs are zero and the counter is stopped. While stopped, tick enables leave the count unchanged and raise no underflow.
- R2: The reload value is written through byte lanes: address 0 writes bits 7:0 and address 1 writes bits 15:8. These writes never change the live count, whether the counter is stopped or running.
- R3: A write of any data to address 2 (start) loads the counter from the reload register on the next clock edge and sets the counter running.
- R4: While running, each cycle with the tick enable high and the count nonzero lowers the count by exactly one. A cycle without a tick leaves the count unchanged.
- R5: A write of any data to address 3 (snapshot) copies the count held before that edge into `snapOut`, with bits 7:0 as the low byte and bits 15:8 as the high byte. `snapOut` holds its value until the next snapshot write.
- R6: A tick while running with the count at zero reloads the counter from the reload register, keeps it running, and sets status bit 0 (underflow).
- R7: A write to address 4 (clear) clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. With no clear write, set bits stay set.
- R8: A cycle with `evtIn` high sets status bit 1 (event).
- R9: When a status bit is cleared and set in the same cycle, it ends up set.
- R10: When a start write and a tick fall in the same cycle, the counter takes the reload value with no decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count enable pulse (2 MHz in the intended use) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0/1 reload bytes, 2 start, 3 snapshot, 4 clear |
| wrData | input | 8 | Write data |
| evtIn | input | 1 | External event, sets status bit 1 |
| snapOut | output | 16 | Snapshot of the count (low byte in bits 7:0) |
| statusOut | output | 2 | Sticky status: bit 0 underflow, bit 1 event |

## Verification
The bench targets the cycles where two actions collide:
- A clear write in the same cycle as an event or an underflow. A design that lets the clear win would lose the interrupt.
- A start write in the same cycle as a tick. A design that lets the tick win would load one count short.
- Reload byte writes while the counter is running. A design that lets them reach the counter would jump the count.

The bench also probes the counter before any start, since a design that runs from reset would underflow at once. It checks that the snapshot holds steady across many ticks, which a design wired to the live count would fail. Finally, it runs a 64000 reload for 100 ticks and checks that the snapshot yields an elapsed time of 50 µs.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic start;   // load counter from reload register
    logic snap;    // copy live count to snapshot
    logic clr;     // write-one-to-clear status
    logic step;    // decrement / underflow this cycle
  } ctrlStrobe_t;

  localparam int STAT_W   = 2;
  localparam int STAT_UNF = 0;
  localparam int STAT_EVT = 1;

endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int NUM_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  output logic [NUM_LANES-1:0] laneWr,
  output ctrlStrobe_t          strobes,
  output logic                 running
);

  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(NUM_LANES);
  localparam logic [ADDR_W-1:0] SNAP_ADDR  = ADDR_W'(NUM_LANES + 1);
  localparam logic [ADDR_W-1:0] CLR_ADDR   = ADDR_W'(NUM_LANES + 2);

  typedef enum logic { ST_IDLE, ST_RUN } runState_t;
  runState_t state;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_laneDec
    assign laneWr[i] = wrEn && (wrAddr == ADDR_W'(i));
  end

  logic startHit;
  assign startHit = wrEn && (wrAddr == START_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         state <= ST_IDLE;
    else if (startHit) state <= ST_RUN;
  end

  assign running = (state == ST_RUN);

  always_comb begin
    strobes.start = startHit;
    strobes.snap  = wrEn && (wrAddr == SNAP_ADDR);
    strobes.clr   = wrEn && (wrAddr == CLR_ADDR);
    // a start in the same cycle overrides the tick
    strobes.step  = running && tickEn && !startHit;
  end

endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BYTE_W    = 8,
  parameter int NUM_LANES = CNT_W / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobes,
  input  logic [NUM_LANES-1:0] laneWr,
  input  logic [BYTE_W-1:0]    wrData,
  input  logic                 evtIn,
  output logic [CNT_W-1:0]     liveCount,
  output logic [CNT_W-1:0]     reloadVal,
  output logic [CNT_W-1:0]     snapOut,
  output logic [STAT_W-1:0]    statusOut
);

  // reload holding register, one byte lane per address
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_reloadLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          reloadVal[i*BYTE_W +: BYTE_W] <= '0;
      else if (laneWr[i]) reloadVal[i*BYTE_W +: BYTE_W] <= wrData;
    end
  end

  logic atZero;
  logic underflow;
  assign atZero    = (liveCount == '0);
  assign underflow = strobes.step && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                liveCount <= '0;
    else if (strobes.start)   liveCount <= reloadVal;
    else if (underflow)       liveCount <= reloadVal;
    else if (strobes.step)    liveCount <= liveCount - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             snapOut <= '0;
    else if (strobes.snap) snapOut <= liveCount;
  end

  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] clrVec;

  always_comb begin
    setVec           = '0;
    setVec[STAT_UNF] = underflow;
    setVec[STAT_EVT] = evtIn;
    clrVec           = strobes.clr ? wrData[STAT_W-1:0] : '0;
  end

  // set takes priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusOut <= '0;
    else       statusOut <= (statusOut & ~clrVec) | setVec;
  end

endmodule

// File: rtl/byte_cdown_timer.sv
module byte_cdown_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              evtIn,
  output logic [CNT_W-1:0]  snapOut,
  output logic [1:0]        statusOut
);

  localparam int NUM_LANES = CNT_W / BYTE_W;

  ctrlStrobe_t          strobes;
  logic [NUM_LANES-1:0] laneWr;
  logic                 runFlag;
  logic [CNT_W-1:0]     liveCount;
  logic [CNT_W-1:0]     reloadVal;

  cdt_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_LANES(NUM_LANES)
  ) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .laneWr (laneWr),
    .strobes(strobes),
    .running(runFlag)
  );

  cdt_datapath #(
    .CNT_W    (CNT_W),
    .BYTE_W   (BYTE_W),
    .NUM_LANES(NUM_LANES)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .laneWr   (laneWr),
    .wrData   (wrData),
    .evtIn    (evtIn),
    .liveCount(liveCount),
    .reloadVal(reloadVal),
    .snapOut  (snapOut),
    .statusOut(statusOut)
  );

endmodule

// File: rtl/byte_cdown_timer_chk.sv
module byte_cdown_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [BYTE_W-1:0] wrData,
  input logic              evtIn,
  input logic [CNT_W-1:0]  snapOut,
  input logic [1:0]        statusOut,
  input logic [CNT_W-1:0]  liveCount,
  input logic [CNT_W-1:0]  reloadVal,
  input logic              runFlag
);

  localparam int NUM_LANES = CNT_W / BYTE_W;

  logic goWr, snapWr, clrWr, laneAny, tickRun;
  assign goWr    = wrEn && (wrAddr == ADDR_W'(NUM_LANES));
  assign snapWr  = wrEn && (wrAddr == ADDR_W'(NUM_LANES + 1));
  assign clrWr   = wrEn && (wrAddr == ADDR_W'(NUM_LANES + 2));
  assign laneAny = wrEn && (int'(wrAddr) < NUM_LANES);
  assign tickRun = runFlag && tickEn && !goWr;

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!runFlag && !goWr) |=> ($stable(liveCount) && !statusOut[0]) || $past(statusOut[0]));

  p_reload_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (laneAny && !tickRun) |=> $stable(liveCount));

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    goWr |=> (runFlag && liveCount == $past(reloadVal)));

  p_tick_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tickRun && liveCount != '0) |=> liveCount == $past(liveCount) - 1'b1);

  p_snap_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    snapWr |=> snapOut == $past(liveCount));

  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !snapWr |=> $stable(snapOut));

  p_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tickRun && liveCount == '0) |=> (statusOut[0] && runFlag && liveCount == $past(reloadVal)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[1] && !(clrWr && wrData[1])) |=> statusOut[1]);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && wrData[1] && !evtIn) |=> !statusOut[1]);

  p_event_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    evtIn |=> statusOut[1]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && wrData[0] && tickRun && liveCount == '0) |=> statusOut[0]);

  p_start_over_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (goWr && tickEn) |=> liveCount == $past(reloadVal));

endmodule

bind byte_cdown_timer byte_cdown_timer_chk #(
  .CNT_W (CNT_W),
  .BYTE_W(BYTE_W),
  .ADDR_W(ADDR_W)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .evtIn    (evtIn),
  .snapOut  (snapOut),
  .statusOut(statusOut),
  .liveCount(liveCount),
  .reloadVal(reloadVal),
  .runFlag  (runFlag)
);

// File: tb/byte_cdown_timer_test.sv
module byte_cdown_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        evtIn = 1'b0;
  logic [15:0] snapOut;
  logic [1:0]  statusOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  byte_cdown_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .evtIn(evtIn),
    .snapOut(snapOut), .statusOut(statusOut)
  );

  typedef struct {
    logic [15:0] snap;
    logic [1:0]  stat;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // bench model state, built from the requirements
  logic [15:0] mReload = '0;
  logic [15:0] mCount  = '0;
  bit          mRun    = 1'b0;
  logic [15:0] mSnap   = '0;
  logic [1:0]  mStat   = '0;
  string       curTag  = "R1";

  // monitor: compares outputs shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (snapOut !== e.snap || statusOut !== e.stat) begin
          failures++;
          $display("FAIL %s snap=%h exp=%h status=%b exp=%b",
                   e.tag, snapOut, e.snap, statusOut, e.stat);
        end
      end
    end
  end

  // driver: apply one cycle of stimulus, advance the model, queue expectation
  task automatic cyc(input bit we, input logic [2:0] a, input logic [7:0] d,
                     input bit tk, input bit ev);
    bit go, unf;
    logic [1:0] clr;
    wrEn = we; wrAddr = a; wrData = d; tickEn = tk; evtIn = ev;
    go  = we && a == 3'd2;
    unf = mRun && tk && !go && mCount == 16'd0;
    if (we && a == 3'd3) mSnap = mCount;
    clr = (we && a == 3'd4) ? d[1:0] : 2'b00;
    mStat = (mStat & ~clr) | {ev, unf};
    if (go) mCount = mReload;
    else if (unf) mCount = mReload;
    else if (mRun && tk) mCount = mCount - 16'd1;
    if (go) mRun = 1'b1;
    if (we && a == 3'd0) mReload[7:0]  = d;
    if (we && a == 3'd1) mReload[15:8] = d;
    expQ.push_back('{mSnap, mStat, curTag});
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0; evtIn = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b1, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values, ticks ignored before start
    curTag = "R1";
    idle(2);
    ticks(5);
    wr(3'd3, 8'h00);

    // R2: reload bytes do not reach the stopped counter
    curTag = "R2";
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h00);
    ticks(3);
    wr(3'd3, 8'h00);

    // R3: start loads reload (16)
    curTag = "R3";
    wr(3'd2, 8'h5A);
    wr(3'd3, 8'h00);

    // R4: ticks decrement, gaps hold
    curTag = "R4";
    ticks(4);
    idle(2);
    wr(3'd3, 8'h00);

    // R5: snapshot holds across ticks until next snapshot
    curTag = "R5";
    ticks(3);
    idle(1);
    wr(3'd3, 8'h00);

    // R6: underflow reloads and sets status bit 0
    curTag = "R6";
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    ticks(4);
    ticks(1);
    wr(3'd3, 8'h00);

    // R7: write-one-to-clear per bit
    curTag = "R7";
    wr(3'd4, 8'h02);
    wr(3'd4, 8'h01);

    // R8: external event is sticky
    curTag = "R8";
    cyc(1'b0, 3'd0, 8'd0, 1'b0, 1'b1);
    idle(2);
    wr(3'd4, 8'h02);

    // R9: set beats clear in the same cycle
    curTag = "R9";
    cyc(1'b1, 3'd4, 8'h03, 1'b0, 1'b1);
    wr(3'd2, 8'h00);
    ticks(3);
    cyc(1'b1, 3'd4, 8'h01, 1'b1, 1'b0);
    wr(3'd4, 8'h03);

    // R10: start and tick together: no decrement
    curTag = "R10";
    cyc(1'b1, 3'd2, 8'h00, 1'b1, 1'b0);
    wr(3'd3, 8'h00);

    // R2: reload write while running leaves count alone
    curTag = "R2";
    wr(3'd0, 8'h05);
    ticks(1);
    wr(3'd3, 8'h00);

    // R4: 64000 reload, 100 ticks -> 63900, 50 us elapsed
    curTag = "R4";
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFA);
    wr(3'd2, 8'h00);
    ticks(100);
    wr(3'd3, 8'h00);
    idle(1);
    checks++;
    if ((16'd64000 - snapOut) / 2 != 50) begin
      failures++;
      $display("FAIL R4 elapsed_us=%0d exp=50", (16'd64000 - snapOut) / 2);
    end

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule